// File: doc/BRIEF.md
# Warp Operand-Issue Packet Formatter

This block sits between a warp scheduler and one SIMD unit. It takes one three-source, one-destination instruction for a whole warp, such as a multiply-add, and turns it into four phase packets. Each phase covers eight lanes, so one warp spans four phases. A 2-bit phase count tracks the phases, and the whole SIMD unit shares that count. The phase count moves on only when the receiving side takes a packet.

The packet has two layouts, and a one-bit flag in the packet tells the receiver which one it holds.

- **Associative layout.** Each lane's work item follows from its lane position and the phase count. The packet therefore carries only the three source register numbers, the destination register number and the phase count, which is 34 bits in total.
- **Coalesced layout.** A coalescer has regrouped the work items, so lane position no longer identifies them. Every lane slot then carries its own 10-bit work-item identifier next to the 32 bits of register numbers, which is 42 bits per lane.

The formatter latches the layout flag, the register numbers, a 32-slot activity mask and the 32 work-item identifiers when it accepts a warp. These values stay fixed for all four phases. The last phase can hand over directly to the next warp, so no idle cycle falls between warps.

Top module: `wpf_issue_fmt`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and `out_assoc`, `out_lanes` and `out_act` are all zero.
- R2: A warp is accepted when `in_valid` and `in_ready` are both high at a clock edge. From the next cycle, `out_valid` is 1 and `out_phase` is 0. The phase then steps 0, 1, 2, 3, moving only on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, every output holds its value.
- R3: When phase 3 is accepted, `out_phase` wraps to 0. If a new request is pending, it is accepted on that same edge, so its phase 0 appears in the next cycle with no idle cycle.
- R4: In associative mode (`out_coal`=0), `out_assoc` holds source 0 in bits [7:0], source 1 in [15:8], source 2 in [23:16], the phase in [25:24] and the destination in [33:26]. `out_lanes` is all zero.
- R5: In coalesced mode (`out_coal`=1), `out_assoc` is zero. Lane l occupies `out_lanes[l*42 +: 42]` as {identifier[41:32], dst[31:24], src2[23:16], src1[15:8], src0[7:0]}. The identifier is taken from warp slot s = phase*8 + l, which is `in_wid[s*10 +: 10]` at the time the warp was accepted.
- R6: In coalesced mode, a lane whose mask bit is 0 carries an all-zero identifier field and still carries the four register numbers.
- R7: `out_act[l]` equals mask bit `in_mask[phase*8 + l]` latched at acceptance, in both modes.
- R8: `out_coal` equals `in_coal` latched at acceptance. Inputs presented while a warp is in flight and not accepted have no effect on any output.
- R9: `in_ready` is low while a warp is in flight, except in the cycle where phase 3 is offered with `out_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Warp request present |
| in_ready | output | 1 | Formatter can take a warp request |
| in_coal | input | 1 | 1 = coalesced layout, 0 = associative layout |
| in_src0 | input | 8 | Source register 0 |
| in_src1 | input | 8 | Source register 1 |
| in_src2 | input | 8 | Source register 2 |
| in_dst | input | 8 | Destination register |
| in_mask | input | 32 | Per-slot active bits; slot = phase*8 + lane |
| in_wid | input | 320 | Per-slot 10-bit work-item identifiers |
| out_valid | output | 1 | Phase packet valid |
| out_ready | input | 1 | Receiver takes the packet |
| out_coal | output | 1 | Layout flag of the current packet |
| out_phase | output | 2 | Shared phase count |
| out_act | output | 8 | Active flags of the eight lanes in this phase |
| out_assoc | output | 34 | Compact associative packet word |
| out_lanes | output | 336 | Eight 42-bit coalesced lane fields |

## Verification
Faults in internal state show up at the ports almost at once.

- **Phase counter.** A counter that skips, repeats or wraps at the wrong point selects the wrong eight mask bits and identifiers in the same cycle. It also puts the wrong value in bits [25:24] of the associative word.
- **Latched mode.** A wrong latched mode flips the layout, zeroing whichever of `out_assoc` and `out_lanes` should be carrying data.
- **Capture logic.** A capture that reloads while a warp is in flight shows in the next cycle: the pending request's registers or identifiers leak into the packet.
- **Busy tracking.** A busy flag that drops late leaves an idle cycle after phase 3, which `out_valid` reveals.

// File: rtl/wpf_pkg.sv
package wpf_pkg;
    localparam int REG_W   = 8;
    localparam int WID_W   = 10;
    localparam int LANES   = 8;
    localparam int PHASES  = 4;
    localparam int PH_W    = $clog2(PHASES);
    localparam int SLOTS   = LANES * PHASES;
    localparam int LANE_W  = WID_W + 4 * REG_W;
    localparam int ASSOC_W = 4 * REG_W + PH_W;

    typedef enum logic {
        MODE_ASSOC = 1'b0,
        MODE_COAL  = 1'b1
    } mode_e;

    typedef struct packed {
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] s2;
        logic [REG_W-1:0] s1;
        logic [REG_W-1:0] s0;
    } regset_t;

    typedef struct packed {
        mode_e                   mode;
        regset_t                 regs;
        logic [SLOTS-1:0]        mask;
        logic [SLOTS*WID_W-1:0]  wids;
    } warp_t;

    function automatic logic [ASSOC_W-1:0] pack_assoc(regset_t r, logic [PH_W-1:0] ph);
        return {r.dst, ph, r.s2, r.s1, r.s0};
    endfunction
endpackage

// File: rtl/wpf_phase_ctr.sv
module wpf_phase_ctr
    import wpf_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            advance,
    output logic            busy,
    output logic [PH_W-1:0] phase,
    output logic            last
);
    assign last = (phase == PH_W'(PHASES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            phase <= '0;
        end else begin
            if (advance) begin
                if (last) phase <= '0;
                else      phase <= phase + PH_W'(1);
            end
            if (start)                busy <= 1'b1;
            else if (advance && last) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/wpf_lane.sv
module wpf_lane
    import wpf_pkg::*;
(
    input  logic              coal,
    input  logic              act,
    input  logic [WID_W-1:0]  wid,
    input  regset_t           regs,
    output logic [LANE_W-1:0] field
);
    always_comb begin
        if (!coal)     field = '0;
        else if (act)  field = {wid, regs};
        else           field = {{WID_W{1'b0}}, regs};
    end
endmodule

// File: rtl/wpf_issue_fmt.sv
module wpf_issue_fmt
    import wpf_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic                    in_coal,
    input  logic [REG_W-1:0]        in_src0,
    input  logic [REG_W-1:0]        in_src1,
    input  logic [REG_W-1:0]        in_src2,
    input  logic [REG_W-1:0]        in_dst,
    input  logic [SLOTS-1:0]        in_mask,
    input  logic [SLOTS*WID_W-1:0]  in_wid,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic                    out_coal,
    output logic [PH_W-1:0]         out_phase,
    output logic [LANES-1:0]        out_act,
    output logic [ASSOC_W-1:0]      out_assoc,
    output logic [LANES*LANE_W-1:0] out_lanes
);
    logic            busy, last, start, advance;
    logic [PH_W-1:0] phase;
    warp_t           warp_q;
    logic            coal_on;
    logic [LANES-1:0] act_slice;

    assign advance  = busy && out_ready;
    assign in_ready = !busy || (last && out_ready);
    assign start    = in_valid && in_ready;

    wpf_phase_ctr u_ctr (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .advance (advance),
        .busy    (busy),
        .phase   (phase),
        .last    (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            warp_q <= '0;
        end else if (start) begin
            warp_q.mode <= in_coal ? MODE_COAL : MODE_ASSOC;
            warp_q.regs <= '{dst: in_dst, s2: in_src2, s1: in_src1, s0: in_src0};
            warp_q.mask <= in_mask;
            warp_q.wids <= in_wid;
        end
    end

    assign coal_on   = busy && (warp_q.mode == MODE_COAL);
    assign act_slice = warp_q.mask[int'(phase)*LANES +: LANES];

    assign out_valid = busy;
    assign out_phase = phase;
    assign out_coal  = busy && (warp_q.mode == MODE_COAL);
    assign out_act   = busy ? act_slice : '0;
    assign out_assoc = (busy && warp_q.mode == MODE_ASSOC) ? pack_assoc(warp_q.regs, phase) : '0;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        wpf_lane u_lane (
            .coal  (coal_on),
            .act   (act_slice[l]),
            .wid   (warp_q.wids[(int'(phase)*LANES + l)*WID_W +: WID_W]),
            .regs  (warp_q.regs),
            .field (out_lanes[l*LANE_W +: LANE_W])
        );
    end
endmodule

// File: rtl/wpf_issue_chk.sv
module wpf_issue_chk
    import wpf_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic                    out_coal,
    input logic [PH_W-1:0]         out_phase,
    input logic [LANES-1:0]        out_act,
    input logic [ASSOC_W-1:0]      out_assoc,
    input logic [LANES*LANE_W-1:0] out_lanes
);
    assert_start_phase0_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (out_valid && out_phase == '0));

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_phase != PH_W'(PHASES-1))
        |=> (out_valid && out_phase == $past(out_phase) + PH_W'(1)));

    assert_stall_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_phase) && $stable(out_lanes)
                                       && $stable(out_assoc) && $stable(out_act)));

    assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_phase == PH_W'(PHASES-1)) |=> (out_phase == '0));

    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !(out_ready && out_phase == PH_W'(PHASES-1))) |=> $stable(out_coal));

    assert_assoc_layout_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_coal) |-> (out_lanes == '0 && out_assoc[3*REG_W +: PH_W] == out_phase));

    assert_coal_word_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_coal) |-> (out_assoc == '0));

    assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !(out_ready && out_phase == PH_W'(PHASES-1))) |-> !in_ready);

    for (genvar l = 0; l < LANES; l++) begin : g_inact
        assert_inactive_zero_R6: assert property (@(posedge clk) disable iff (rst)
            (out_valid && out_coal && !out_act[l]) |-> (out_lanes[l*LANE_W + 4*REG_W +: WID_W] == '0));
    end
endmodule

bind wpf_issue_fmt wpf_issue_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_coal  (out_coal),
    .out_phase (out_phase),
    .out_act   (out_act),
    .out_assoc (out_assoc),
    .out_lanes (out_lanes)
);

// File: tb/tb_wpf_issue_fmt.sv
module tb_wpf_issue_fmt;
    localparam int CLK_PERIOD = 10;
    localparam int NWARPS     = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic         in_coal = 1'b0;
    logic [7:0]   in_src0 = '0, in_src1 = '0, in_src2 = '0, in_dst = '0;
    logic [31:0]  in_mask = '0;
    logic [319:0] in_wid = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic         out_coal;
    logic [1:0]   out_phase;
    logic [7:0]   out_act;
    logic [33:0]  out_assoc;
    logic [335:0] out_lanes;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wpf_issue_fmt dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_coal(in_coal),
        .in_src0(in_src0), .in_src1(in_src1), .in_src2(in_src2), .in_dst(in_dst),
        .in_mask(in_mask), .in_wid(in_wid), .out_valid(out_valid), .out_ready(out_ready),
        .out_coal(out_coal), .out_phase(out_phase), .out_act(out_act),
        .out_assoc(out_assoc), .out_lanes(out_lanes)
    );

    task automatic chk(string req, logic [399:0] act, logic [399:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic w_coal(int w);
        return (w % 3) != 0;
    endfunction
    function automatic logic [7:0] w_reg(int w, int k);
        return 8'((w * (3 + 2*k) + k * 41 + 5) & 255);
    endfunction
    function automatic logic [31:0] w_mask(int w);
        if (w == 1) return 32'hFFFF_FFFF;
        if (w == 2) return 32'h0000_0000;
        if (w == 4) return 32'hA5A5_5A5A;
        return 32'((w + 1) * 32'h9E37_79B9);
    endfunction
    function automatic logic [9:0] w_id(int w, int slot);
        return 10'((w * 37 + slot * 13 + 7) & 1023);
    endfunction

    task automatic present(int w);
        in_coal = w_coal(w);
        in_src0 = w_reg(w, 0);
        in_src1 = w_reg(w, 1);
        in_src2 = w_reg(w, 2);
        in_dst  = w_reg(w, 3);
        in_mask = w_mask(w);
        for (int s = 0; s < 32; s++) in_wid[s*10 +: 10] = w_id(w, s);
        in_valid = 1'b1;
    endtask

    task automatic check_phase(int w, int p, logic rdy_exp, string tag);
        logic [33:0]  ea;
        logic [335:0] el;
        logic [7:0]   em;
        logic [31:0]  m;
        m  = w_mask(w);
        em = m[p*8 +: 8];
        ea = w_coal(w) ? '0 : {w_reg(w,3), 2'(p), w_reg(w,2), w_reg(w,1), w_reg(w,0)};
        el = '0;
        if (w_coal(w))
            for (int l = 0; l < 8; l++)
                el[l*42 +: 42] = {(em[l] ? w_id(w, p*8+l) : 10'd0),
                                  w_reg(w,3), w_reg(w,2), w_reg(w,1), w_reg(w,0)};
        chk({"R2 valid ", tag}, 400'(out_valid), 400'(1));
        chk({"R2 phase ", tag}, 400'(out_phase), 400'(p));
        chk({"R8 mode ", tag}, 400'(out_coal), 400'(w_coal(w)));
        chk({"R7 act ", tag}, 400'(out_act), 400'(em));
        chk({"R4 assoc word ", tag}, 400'(out_assoc), 400'(ea));
        chk({"R5 R6 lanes ", tag}, 400'(out_lanes), 400'(el));
        chk({"R9 in_ready ", tag}, 400'(in_ready), 400'(rdy_exp));
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 out_valid", 400'(out_valid), 400'(0));
        chk("R1 in_ready", 400'(in_ready), 400'(1));
        chk("R1 outputs zero", 400'({out_assoc, out_lanes, out_act}), 400'(0));
        @(negedge clk);
        chk("R1 idle stays", 400'(out_valid), 400'(0));

        present(0);
        @(negedge clk);
        for (int w = 0; w < NWARPS; w++) begin
            // next warp held pending while this one is in flight (R8, R3)
            if (w + 1 < NWARPS) present(w + 1);
            else in_valid = 1'b0;
            for (int p = 0; p < 4; p++) begin
                for (int k = 0; k < (w + p) % 3; k++) begin
                    out_ready = 1'b0;
                    #1;
                    check_phase(w, p, 1'b0, $sformatf("stall w%0d p%0d", w, p));
                    @(negedge clk);
                end
                out_ready = 1'b1;
                #1;
                check_phase(w, p, (p == 3), $sformatf("w%0d p%0d", w, p));
                @(negedge clk);
            end
        end
        out_ready = 1'b0;
        #1;
        chk("R3 drained idle", 400'(out_valid), 400'(0));
        chk("R3 phase wrapped", 400'(out_phase), 400'(0));
        chk("R1 ready after drain", 400'(in_ready), 400'(1));

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule